// File: doc/BRIEF.md
# Multichannel Audio Transmit Sample FIFO

This block buffers outgoing audio samples between a processor and a serial audio transmitter. Software writes 24-bit sample words into a data register, and a serializer drains them one word per channel slot. A format register picks the framing mode and, for the time-division modes, the number of channels. The words are stored in one shared array of fixed total size. The capacity granted to each channel shrinks as the channel count grows, so the same storage serves mono, stereo and up to eight-channel frames.

A status register reports how many whole frames are buffered. It also holds two sticky error flags: one for writes dropped because the buffer was full, and one for drain requests made while it was empty. A control register can flush the buffer and can enable a refill interrupt. That interrupt stays high while the buffer is at or below half of its per-channel capacity. The register port is a single-cycle write strobe with a combinational read-back.

The serializer side is valid/ready. `slot_valid` is high whenever at least one word is buffered, and `slot_data` then shows the oldest word. A word is consumed on a clock edge where both `slot_valid` and `slot_ready` are high. While the serializer holds `slot_ready` low, the offered word and `slot_valid` stay put. There is no back-pressure toward the processor: a write that finds the buffer full is lost and is flagged instead.

Top module: `audio_tx_fifo`

## Requirements
- R1: A write to the data register (address 3) stores only bits 23:0 of the bus word. Stored words leave on `slot_data` in the order they were written.
- R2: The format register (address 0) holds the mode in bits 6:4 and a channel code in bits 2:0, and it reads back as written. The mode codes are 0 and 1 for mono (1 channel), 2 and 3 for two-channel, and 4 and 5 for TDM, where the channel count is the code plus one. A format write whose mode is 6 or 7 is ignored entirely and does not flush. After reset the format is mono.
- R3: The per-channel capacity is 256 words for 1 channel, 128 for 2, 64 for 3 or 4, and 32 for 5 to 8. The total capacity is the per-channel value times the channel count. A data write when the total is reached is dropped and sets the overrun flag (status bit 4).
- R4: Status register (address 2) bits 16:8 hold the number of buffered words divided by the channel count, rounded down. All other unlisted status bits read zero.
- R5: When the buffer is empty, `slot_valid` is low and `slot_data` is zero. A cycle with `slot_ready` high while empty sets the underrun flag (status bit 0).
- R6: The overrun and underrun flags stay set until a write of zero to the status register or a flush. A nonzero status write has no effect. A clear takes priority over a set in the same cycle.
- R7: Writing the control register (address 1) with bit 0 set flushes all buffered words and clears both flags. Bit 20 is the interrupt enable and reads back at bit 20. Bit 0 always reads zero. After reset the interrupt is disabled.
- R8: `irq` is high exactly when the interrupt is enabled and the frame count from R4 is at or below half the per-channel capacity.
- R9: An accepted format write empties the buffer, while the error flags keep their values.
- R10: While `slot_valid` is high and `slot_ready` is low, the next cycle still has `slot_valid` high with the same `slot_data`, unless a flush occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 format, 1 control, 2 status, 3 data |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational); data address reads zero |
| slot_valid | output | 1 | A buffered word is offered |
| slot_ready | input | 1 | Serializer takes the offered word / requests one |
| slot_data | output | 24 | Oldest buffered word, zero when empty |
| irq | output | 1 | Half-level refill interrupt |

## Verification
A broken read or write pointer shows up on `slot_data` as a word out of order or a repeated word. Because each pointer wraps at the configured total capacity and not at a power of two, such a fault may only appear after a full wrap in the three- and five-channel layouts. A wrong occupancy count becomes visible at once, at the next status read or in `irq`, and it also shifts the point at which overrun is raised, by as many words as the count is off. A flag that fails to stick, or a flush that leaves a word behind, is visible in the very next cycle through the status register and `slot_valid`.

// File: rtl/atf_pkg.sv
package atf_pkg;

  localparam int CHAN_W = 4;

  typedef enum logic [1:0] {
    RA_FMT  = 2'd0,
    RA_CTRL = 2'd1,
    RA_STAT = 2'd2,
    RA_DATA = 2'd3
  } reg_addr_e;

  typedef enum logic [2:0] {
    FM_MONO     = 3'd0,
    FM_MONO_DLY = 3'd1,
    FM_PCM      = 3'd2,
    FM_I2S      = 3'd3,
    FM_TDM      = 3'd4,
    FM_TDM_DLY  = 3'd5
  } fmt_mode_e;

  // field positions decoded by software and the bench
  localparam int FM_MODE_LSB = 4;
  localparam int CT_CLR_BIT  = 0;
  localparam int CT_HALF_BIT = 20;
  localparam int ST_UND_BIT  = 0;
  localparam int ST_OVR_BIT  = 4;
  localparam int ST_FILL_LSB = 8;

  function automatic logic [CHAN_W-1:0] chan_count(input logic [2:0] mode,
                                                   input logic [2:0] code);
    logic [CHAN_W-1:0] n;
    case (mode)
      FM_MONO, FM_MONO_DLY: n = CHAN_W'(1);
      FM_PCM, FM_I2S:       n = CHAN_W'(2);
      default:              n = CHAN_W'(code) + CHAN_W'(1);
    endcase
    return n;
  endfunction

  // log2 of the divisor applied to total storage for the per-channel share
  function automatic logic [1:0] depth_shift(input logic [CHAN_W-1:0] ch);
    logic [1:0] s;
    if (ch == CHAN_W'(1))      s = 2'd0;
    else if (ch == CHAN_W'(2)) s = 2'd1;
    else if (ch <= CHAN_W'(4)) s = 2'd2;
    else                       s = 2'd3;
    return s;
  endfunction

endpackage

// File: rtl/atf_store.sv
module atf_store #(
  parameter int DATA_W = 24,
  parameter int DEPTH  = 256,
  parameter int PTR_W  = 8,
  parameter int CNT_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  input  logic [CNT_W-1:0]  cap_words,
  output logic              slot_valid,
  output logic [DATA_W-1:0] slot_data,
  output logic [CNT_W-1:0]  fill_words,
  output logic              ovr_ev,
  output logic              und_ev
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt;
  logic              empty, full, do_push, do_pop;
  logic [CNT_W-1:0]  last_idx;
  logic [PTR_W-1:0]  wr_nxt, rd_nxt;

  always_comb begin
    empty    = (cnt == '0);
    full     = (cnt >= cap_words);
    do_push  = push && !full;
    do_pop   = pop_req && !empty;
    last_idx = cap_words - CNT_W'(1);
    wr_nxt   = (CNT_W'(wr_ptr) == last_idx) ? '0 : wr_ptr + PTR_W'(1);
    rd_nxt   = (CNT_W'(rd_ptr) == last_idx) ? '0 : rd_ptr + PTR_W'(1);
    ovr_ev   = push && full;
    und_ev   = pop_req && empty;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_nxt;
      if (do_pop)  rd_ptr <= rd_nxt;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign slot_valid = !empty;
  assign slot_data  = empty ? '0 : mem[rd_ptr];
  assign fill_words = cnt;

endmodule

// File: rtl/atf_level.sv
module atf_level
  import atf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CNT_W = 9
) (
  input  logic [2:0]        mode,
  input  logic [2:0]        code,
  input  logic [CNT_W-1:0]  fill_words,
  input  logic              irq_en,
  output logic [CHAN_W-1:0] chans,
  output logic [CNT_W-1:0]  cap_words,
  output logic [CNT_W-1:0]  fill_frames,
  output logic              irq
);

  localparam int PROD_W = CNT_W + CHAN_W;

  logic [CNT_W-1:0]  per_ch, half;
  logic [PROD_W-1:0] prod;

  always_comb begin
    chans       = chan_count(mode, code);
    per_ch      = CNT_W'(DEPTH >> depth_shift(chans));
    prod        = PROD_W'(per_ch) * PROD_W'(chans);
    cap_words   = prod[CNT_W-1:0];
    fill_frames = fill_words / CNT_W'(chans);
    half        = per_ch >> 1;
    irq         = irq_en && (fill_frames <= half);
  end

endmodule

// File: rtl/atf_regs.sv
module atf_regs
  import atf_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int DATA_W = 24,
  parameter int CNT_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [CNT_W-1:0]  fill_frames,
  input  logic              ovr_ev,
  input  logic              und_ev,
  output logic [2:0]        mode_q,
  output logic [2:0]        code_q,
  output logic              irq_en,
  output logic              flush,
  output logic              flag_clr,
  output logic              push,
  output logic [DATA_W-1:0] push_data,
  output logic              ovr_q,
  output logic              und_q
);

  logic wr_fmt, wr_ctrl, wr_stat, fmt_ok, clr_strobe;

  always_comb begin
    wr_fmt     = bus_we && (bus_addr == RA_FMT);
    wr_ctrl    = bus_we && (bus_addr == RA_CTRL);
    wr_stat    = bus_we && (bus_addr == RA_STAT);
    push       = bus_we && (bus_addr == RA_DATA);
    push_data  = bus_wdata[DATA_W-1:0];
    fmt_ok     = wr_fmt && (bus_wdata[FM_MODE_LSB +: 3] <= FM_TDM_DLY);
    clr_strobe = wr_ctrl && bus_wdata[CT_CLR_BIT];
    flush      = clr_strobe || fmt_ok;
    flag_clr   = clr_strobe || (wr_stat && (bus_wdata == '0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= FM_MONO;
      code_q <= '0;
      irq_en <= 1'b0;
    end else begin
      if (fmt_ok) begin
        mode_q <= bus_wdata[FM_MODE_LSB +: 3];
        code_q <= bus_wdata[2:0];
      end
      if (wr_ctrl) irq_en <= bus_wdata[CT_HALF_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flag_clr) begin
      ovr_q <= 1'b0;
      und_q <= 1'b0;
    end else begin
      if (ovr_ev) ovr_q <= 1'b1;
      if (und_ev) und_q <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_FMT: begin
        bus_rdata[FM_MODE_LSB +: 3] = mode_q;
        bus_rdata[2:0]              = code_q;
      end
      RA_CTRL: bus_rdata[CT_HALF_BIT] = irq_en;
      RA_STAT: begin
        bus_rdata[ST_FILL_LSB +: CNT_W] = fill_frames;
        bus_rdata[ST_OVR_BIT]           = ovr_q;
        bus_rdata[ST_UND_BIT]           = und_q;
      end
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo
  import atf_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int DATA_W = 24,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              slot_valid,
  input  logic              slot_ready,
  output logic [DATA_W-1:0] slot_data,
  output logic              irq
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [2:0]        mode_q, code_q;
  logic              irq_en, flush, flag_clr, push;
  logic [DATA_W-1:0] push_data;
  logic              ovr_flag, und_flag, ovr_ev, und_ev;
  logic [CHAN_W-1:0] chans;
  logic [CNT_W-1:0]  cap_words, fill_words, fill_frames;

  atf_regs #(.BUS_W(BUS_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fill_frames(fill_frames),
    .ovr_ev(ovr_ev), .und_ev(und_ev), .mode_q(mode_q), .code_q(code_q),
    .irq_en(irq_en), .flush(flush), .flag_clr(flag_clr), .push(push),
    .push_data(push_data), .ovr_q(ovr_flag), .und_q(und_flag)
  );

  atf_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_level (
    .mode(mode_q), .code(code_q), .fill_words(fill_words), .irq_en(irq_en),
    .chans(chans), .cap_words(cap_words), .fill_frames(fill_frames), .irq(irq)
  );

  atf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .push_data(push_data),
    .pop_req(slot_ready), .cap_words(cap_words), .slot_valid(slot_valid),
    .slot_data(slot_data), .fill_words(fill_words), .ovr_ev(ovr_ev), .und_ev(und_ev)
  );

endmodule

// File: rtl/atf_checker.sv
module atf_checker #(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slot_valid,
  input logic              slot_ready,
  input logic [DATA_W-1:0] slot_data,
  input logic              irq,
  input logic              irq_en,
  input logic              ovr_flag,
  input logic              und_flag,
  input logic              flag_clr,
  input logic              flush,
  input logic              push,
  input logic [CNT_W-1:0]  fill_words,
  input logic [CNT_W-1:0]  cap_words
);

  AST_FILL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    fill_words <= cap_words); // R3

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush && (fill_words >= cap_words) && !flag_clr) |=> ovr_flag); // R3

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_valid |-> (slot_data == '0)); // R5

  AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_ready && !slot_valid && !flag_clr) |=> und_flag); // R5

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovr_flag || und_flag) && !flag_clr) |=> (ovr_flag || und_flag)); // R6

  AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> (!ovr_flag && !und_flag)); // R6

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !slot_valid); // R9

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq); // R8

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && !slot_ready && !flush) |=> (slot_valid && $stable(slot_data))); // R10

endmodule

bind audio_tx_fifo atf_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_ready(slot_ready),
  .slot_data(slot_data), .irq(irq), .irq_en(irq_en), .ovr_flag(ovr_flag),
  .und_flag(und_flag), .flag_clr(flag_clr), .flush(flush), .push(push),
  .fill_words(fill_words), .cap_words(cap_words)
);

// File: tb/sim_audio_tx_fifo.sv
module sim_audio_tx_fifo;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        slot_valid;
  logic        slot_ready = 1'b0;
  logic [23:0] slot_data;
  logic        irq;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  logic [23:0] q[$];
  int          ch = 1;
  bit          exp_ovr = 1'b0;
  bit          exp_und = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  audio_tx_fifo u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .slot_valid(slot_valid),
    .slot_ready(slot_ready), .slot_data(slot_data), .irq(irq)
  );

  function automatic int cap_of(int c);
    int per;
    if (c == 1)      per = 256;
    else if (c == 2) per = 128;
    else if (c <= 4) per = 64;
    else             per = 32;
    return per * c;
  endfunction

  function automatic logic [31:0] exp_status();
    return ((32'(q.size()) / 32'(ch)) << 8) | (32'(exp_ovr) << 4) | 32'(exp_und);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(posedge clk);
    #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic push(logic [31:0] d);
    wr(2'd3, d);
    if (q.size() < cap_of(ch)) q.push_back(d[23:0]);
    else exp_ovr = 1'b1;
  endtask

  task automatic drain();
    int guard = 0;
    slot_ready = 1'b1;
    do begin
      @(posedge clk);
      #1;
      guard++;
    end while (q.size() != 0 && guard < 1000);
    slot_ready = 1'b0;
  endtask

  // monitor: a transfer happens at the next rising edge when both are high
  always @(negedge clk) begin
    if (rst_n && slot_valid && slot_ready) begin
      if (q.size() == 0) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R1 unexpected word actual=%h expected=none", slot_data);
      end else begin
        chk("R1 word order/truncation", 32'(slot_data), 32'(q.pop_front()));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (4) @(posedge clk);
    #1;
    rst_n = 1'b1;

    // reset state
    rd(2'd0, r); chk("R2 reset format", r, 32'h0);
    rd(2'd1, r); chk("R7 reset control", r, 32'h0);
    rd(2'd2, r); chk("R4 reset status", r, 32'h0);
    chk("R5 reset valid", 32'(slot_valid), 32'h0);
    chk("R8 reset irq", 32'(irq), 32'h0);

    // two-channel, truncation and fill in frames
    wr(2'd0, 32'h20); ch = 2;
    rd(2'd0, r); chk("R2 format readback", r, 32'h20);
    push(32'hAB123456); push(32'hFF000001); push(32'h00FFFFFF);
    push(32'h12345678); push(32'h80ABCDEF);
    rd(2'd2, r); chk("R4 fill 5 words / 2 ch", r, exp_status());
    wr(2'd1, 32'h0010_0000);
    rd(2'd1, r); chk("R7 enable readback", r, 32'h0010_0000);
    chk("R8 irq low fill", 32'(irq), 32'h1);

    // stall holds the offered word
    chk("R10 valid while stalled", 32'(slot_valid), 32'h1);
    chk("R10 head word", 32'(slot_data), 32'(q[0]));
    repeat (2) @(posedge clk);
    #1;
    chk("R10 head word held", 32'(slot_data), 32'(q[0]));

    // drain then one request on empty
    drain();
    slot_ready = 1'b1;
    @(posedge clk);
    #1;
    slot_ready = 1'b0;
    exp_und = 1'b1;
    chk("R5 valid low when empty", 32'(slot_valid), 32'h0);
    chk("R5 zero data when empty", 32'(slot_data), 32'h0);
    rd(2'd2, r); chk("R5 underrun flag", r, exp_status());
    wr(2'd2, 32'h5);
    rd(2'd2, r); chk("R6 nonzero write keeps flag", r, exp_status());
    wr(2'd2, 32'h0); exp_und = 1'b0;
    rd(2'd2, r); chk("R6 zero write clears", r, exp_status());

    // mono: half-level boundary and overrun
    wr(2'd0, 32'h00); ch = 1;
    for (int i = 0; i < 128; i++) push(32'hC000_0000 | 32'(i * 7));
    chk("R8 irq at half", 32'(irq), 32'h1);
    push(32'h0000_0AAA);
    chk("R8 irq above half", 32'(irq), 32'h0);
    for (int i = 129; i < 256; i++) push(32'h3300_0000 | 32'(i * 3));
    push(32'h00DEAD00);
    rd(2'd2, r); chk("R3 full mono plus overrun", r, exp_status());

    // control flush
    wr(2'd1, 32'h0010_0001); q.delete(); exp_ovr = 1'b0;
    rd(2'd2, r); chk("R7 flush clears status", r, 32'h0);
    chk("R7 flush empties", 32'(slot_valid), 32'h0);
    rd(2'd1, r); chk("R7 clear bit reads zero", r, 32'h0010_0000);

    // TDM three channels: 192 words
    wr(2'd0, 32'h42); ch = 3;
    rd(2'd0, r); chk("R2 TDM format readback", r, 32'h42);
    for (int i = 0; i < 193; i++) push(32'(i + 5));
    rd(2'd2, r); chk("R3 three-channel capacity", r, exp_status());

    // format change flushes, flags kept
    wr(2'd0, 32'h51); ch = 2; q.delete();
    rd(2'd2, r); chk("R9 format flush keeps flag", r, exp_status());
    chk("R9 format flush empties", 32'(slot_valid), 32'h0);
    wr(2'd2, 32'h0); exp_ovr = 1'b0;

    // illegal mode is ignored
    push(32'h0000_0111); push(32'h0000_0222); push(32'h0000_0333);
    wr(2'd0, 32'h60);
    rd(2'd0, r); chk("R2 illegal mode ignored", r, 32'h51);
    rd(2'd2, r); chk("R2 illegal mode no flush", r, exp_status());
    drain();
    rd(2'd2, r); chk("R5 clean drain no underrun", r, 32'h0);

    // five channels
    wr(2'd0, 32'h44); ch = 5;
    for (int i = 0; i < 7; i++) push(32'h00A0_0000 + 32'(i));
    rd(2'd2, r); chk("R4 fill 7 words / 5 ch", r, exp_status());
    chk("R8 irq five channels", 32'(irq), 32'h1);
    drain();

    // mono delayed
    wr(2'd0, 32'h10); ch = 1;
    push(32'h1); push(32'h2); push(32'h3);
    rd(2'd2, r); chk("R2 mono delayed one channel", r, exp_status());
    drain();
    chk("R1 all words delivered", 32'(q.size()), 32'h0);

    finish_run();
  end

endmodule